// File: doc/BRIEF.md
# Serial EEPROM configuration loader

After reset this block reads a complete 64-word, 16-bit image from a three-wire serial EEPROM and decides whether the image can be trusted. Each word is fetched with its own read command. The block drives chip-select, the serial clock and the command data line, and it samples the data returned by the device. A programmable timer sets the serial clock's half-period in system clock cycles, so a short value can stand in for the slow real timing.

While the words arrive, the block keeps a 16-bit wrapping checksum. It also keeps the first 16 words (32 bytes of per-target option records) and captures the adapter fields it needs. After the last word it publishes the results. If the checksum is good, the block decodes:

- the adapter bus ID,
- the tagged-command queue depth, which is a power of two,
- an active-negation enable.

If the checksum is bad, default values are published instead. A done flag marks the end of loading. The outputs never change after that until the next reset.

Top module: `eeprom_cfg_loader`

## Requirements
- R1: While reset is active and throughout loading: `ee_cs` and `ee_sk` are low at reset, `cfg_done` and `cfg_valid` are 0, `bus_id` is 7, `queue_depth` is 0 and `act_neg` is 0.
- R2: Words are read in address order 0 to 63, one command per chip-select window. Each command is 9 bits on `ee_di`, taken at each rising `ee_sk` and sent MSB first: a 1 start bit, then 1, 0, then the 6-bit word address. `ee_sk` never rises while `ee_cs` is low.
- R3: Each serial clock phase lasts `HALF_CYC` cycles. A command bit is set up with `ee_sk` low, `ee_sk` is then high for one half-period, and then `ee_sk` and `ee_di` are both low for one half-period. `ee_di` changes only while `ee_sk` is low.
- R4: After the command, 16 data bits are clocked in MSB first. Each bit has `ee_sk` low for one half-period and then high for one half-period, and `ee_do` is sampled at the end of the high half. The device may update `ee_do` on the rising `ee_sk`.
- R5: `ee_cs` stays low for at least one half-period before each word's command.
- R6: `cfg_done` rises exactly 3840*`HALF_CYC`+1 cycles after reset is released. From then on it stays high, and `cfg_valid`, `bus_id`, `queue_depth` and `act_neg` hold stable with no further serial clocks.
- R7: When the 16-bit wrapping sum of all 64 words equals 0x1234, the block sets `cfg_valid` to 1. It also sets `bus_id` to bits 7:0 of word 32 (byte 0x40) and `act_neg` to bit 11 of word 32 (bit 3 of byte 0x41).
- R8: On a valid image, `queue_depth` = 2 << E, where E is bits 15:8 of word 33 (byte 0x43). Any E above `MAX_EXP` (default 15) saturates to 2 << `MAX_EXP` (65536).
- R9: On a checksum mismatch, `cfg_done` still rises, but `cfg_valid`, `bus_id`, `queue_depth` and `act_neg` keep their R1 values.
- R10: `tgt_byte` returns per-target byte `tgt_sel` (0..31) of the image, whatever the checksum. An even byte is bits 7:0 and an odd byte is bits 15:8 of word `tgt_sel`/2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; starts a load |
| ee_cs | output | 1 | EEPROM chip-select |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_di | output | 1 | Command data to the EEPROM |
| ee_do | input | 1 | Read data from the EEPROM |
| tgt_sel | input | 5 | Per-target option byte index |
| tgt_byte | output | 8 | Selected per-target option byte |
| cfg_done | output | 1 | Loading finished |
| cfg_valid | output | 1 | Image checksum matched |
| bus_id | output | 8 | Adapter bus ID |
| queue_depth | output | MAX_EXP+2 | Tagged-command queue depth |
| act_neg | output | 1 | Active-negation enable |

## Verification
The serial results are checked as they happen, not after a delay:

- A behavioural EEPROM model in the bench pops each expected command from a queue at the ninth rising `ee_sk` of a chip-select window.
- The model puts each data bit on the wire at a rising `ee_sk`, so the block's sample point falls a whole half-period later.
- Pulse widths and chip-select gaps are measured on the falling system clock, so no check races a register update.

The configuration results are due exactly 3840*`HALF_CYC`+1 clock edges after reset is released. The bench counts edges and requires `cfg_done` to appear on that edge and no other. It then samples `bus_id`, `queue_depth`, `act_neg`, `cfg_valid` and the per-target bytes, and checks again 50 cycles later that nothing has moved.

// File: rtl/eecfg_pkg.sv
package eecfg_pkg;

    localparam int WORD_W     = 16;
    localparam int ADDR_W     = 6;
    localparam int NWORDS     = 1 << ADDR_W;
    localparam int CMD_BITS   = 3 + ADDR_W;
    localparam int TGT_WORDS  = 16;
    localparam int TGT_SEL_W  = $clog2(TGT_WORDS) + 1;
    localparam logic [WORD_W-1:0] CHECK_MAGIC = 16'h1234;
    localparam logic [7:0]        DEF_BUS_ID  = 8'd7;
    localparam logic [ADDR_W-1:0] ID_WORD     = 6'd32;
    localparam logic [ADDR_W-1:0] EXP_WORD    = 6'd33;
    localparam int                NEG_BIT     = 11;

    typedef enum logic [1:0] {PH_GAP, PH_CMD, PH_DAT, PH_FIN} phase_e;

    // Serial command: start bit, read opcode 2'b10, word address, MSB first
    function automatic logic cmd_bit(input logic [ADDR_W-1:0] idx, input logic [3:0] k);
        logic [CMD_BITS-1:0] c;
        c = {1'b1, 2'b10, idx};
        return c[4'(CMD_BITS-1) - k];
    endfunction

endpackage

// File: rtl/eecfg_tick.sv
module eecfg_tick #(
    parameter int HALF_CYC = 16000
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CW = $clog2(HALF_CYC + 1);

    logic [CW-1:0] cnt;

    assign tick = (cnt == CW'(HALF_CYC - 1));

    always_ff @(posedge clk) begin
        if (rst || tick) cnt <= '0;
        else             cnt <= cnt + 1'b1;
    end

    // R3
    tick_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(HALF_CYC - 1));
endmodule

// File: rtl/eecfg_serial.sv
module eecfg_serial
    import eecfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              ee_do,
    output logic              ee_cs,
    output logic              ee_sk,
    output logic              ee_di,
    output logic              word_stb,
    output logic [ADDR_W-1:0] word_idx,
    output logic [WORD_W-1:0] word_data
);
    phase_e            phase;
    logic [ADDR_W-1:0] widx;
    logic [4:0]        bidx;
    logic [1:0]        sub;
    logic [WORD_W-2:0] sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_GAP;
            widx      <= '0;
            bidx      <= '0;
            sub       <= '0;
            sh        <= '0;
            word_stb  <= 1'b0;
            word_idx  <= '0;
            word_data <= '0;
        end else begin
            word_stb <= 1'b0;
            if (tick) begin
                unique case (phase)
                    PH_GAP: begin
                        phase <= PH_CMD;
                        bidx  <= '0;
                        sub   <= '0;
                    end
                    PH_CMD: begin
                        if (sub == 2'd2) begin
                            sub <= '0;
                            if (bidx == 5'(CMD_BITS - 1)) begin
                                phase <= PH_DAT;
                                bidx  <= '0;
                            end else begin
                                bidx <= bidx + 5'd1;
                            end
                        end else begin
                            sub <= sub + 2'd1;
                        end
                    end
                    PH_DAT: begin
                        if (sub == 2'd0) begin
                            sub <= 2'd1;
                        end else begin
                            sub <= '0;
                            sh  <= {sh[WORD_W-3:0], ee_do};
                            if (bidx == 5'(WORD_W - 1)) begin
                                word_stb  <= 1'b1;
                                word_data <= {sh, ee_do};
                                word_idx  <= widx;
                                bidx      <= '0;
                                if (widx == ADDR_W'(NWORDS - 1)) begin
                                    phase <= PH_FIN;
                                end else begin
                                    widx  <= widx + 1'b1;
                                    phase <= PH_GAP;
                                end
                            end else begin
                                bidx <= bidx + 5'd1;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign ee_cs = (phase == PH_CMD) || (phase == PH_DAT);
    assign ee_sk = ee_cs && (sub == 2'd1);
    assign ee_di = (phase == PH_CMD) && (sub != 2'd2) && cmd_bit(widx, bidx[3:0]);

    // R3
    di_setup_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(ee_di) |-> !ee_sk);
    // R2
    sk_in_cs_chk: assert property (@(posedge clk) disable iff (rst)
        ee_sk |-> ee_cs);
    // R5
    gap_after_word_chk: assert property (@(posedge clk) disable iff (rst)
        word_stb |-> !ee_cs);
endmodule

// File: rtl/eecfg_image.sv
module eecfg_image
    import eecfg_pkg::*;
#(
    parameter int MAX_EXP = 15,
    parameter int DEPTH_W = MAX_EXP + 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 word_stb,
    input  logic [ADDR_W-1:0]    word_idx,
    input  logic [WORD_W-1:0]    word_data,
    input  logic [TGT_SEL_W-1:0] tgt_sel,
    output logic [7:0]           tgt_byte,
    output logic                 cfg_done,
    output logic                 cfg_valid,
    output logic [7:0]           bus_id,
    output logic [DEPTH_W-1:0]   queue_depth,
    output logic                 act_neg
);
    logic [WORD_W-1:0] sum;
    logic [WORD_W-1:0] nsum;
    logic [WORD_W-1:0] tgt_mem [TGT_WORDS];
    logic [7:0]        id_q;
    logic              neg_q;
    logic [7:0]        exp_q;
    logic [WORD_W-1:0] sel_word;

    function automatic logic [DEPTH_W-1:0] depth_of(input logic [7:0] e);
        if (e > 8'(MAX_EXP)) return DEPTH_W'(1) << (MAX_EXP + 1);
        return DEPTH_W'(2) << e;
    endfunction

    assign nsum = sum + word_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            sum         <= '0;
            id_q        <= '0;
            neg_q       <= 1'b0;
            exp_q       <= '0;
            cfg_done    <= 1'b0;
            cfg_valid   <= 1'b0;
            bus_id      <= DEF_BUS_ID;
            queue_depth <= '0;
            act_neg     <= 1'b0;
            for (int i = 0; i < TGT_WORDS; i++) tgt_mem[i] <= '0;
        end else if (word_stb && !cfg_done) begin
            sum <= nsum;
            if (word_idx < ADDR_W'(TGT_WORDS))
                tgt_mem[word_idx[TGT_SEL_W-2:0]] <= word_data;
            if (word_idx == ID_WORD) begin
                id_q  <= word_data[7:0];
                neg_q <= word_data[NEG_BIT];
            end
            if (word_idx == EXP_WORD) exp_q <= word_data[15:8];
            if (word_idx == ADDR_W'(NWORDS - 1)) begin
                cfg_done <= 1'b1;
                if (nsum == CHECK_MAGIC) begin
                    cfg_valid   <= 1'b1;
                    bus_id      <= id_q;
                    act_neg     <= neg_q;
                    queue_depth <= depth_of(exp_q);
                end
            end
        end
    end

    assign sel_word = tgt_mem[tgt_sel[TGT_SEL_W-1:1]];
    assign tgt_byte = tgt_sel[0] ? sel_word[15:8] : sel_word[7:0];

    // R6
    done_hold_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_done |=> cfg_done);
    // R6
    cfg_stable_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_done |=> ($stable(bus_id) && $stable(queue_depth) && $stable(act_neg) && $stable(cfg_valid)));
    // R9
    valid_needs_done_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_valid |-> cfg_done);
    // R1
    default_while_loading_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg_done |-> (bus_id == DEF_BUS_ID && queue_depth == '0 && !act_neg));
    // R8
    depth_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(queue_depth));
endmodule

// File: rtl/eeprom_cfg_loader.sv
module eeprom_cfg_loader
    import eecfg_pkg::*;
#(
    parameter int HALF_CYC = 16000,
    parameter int MAX_EXP  = 15,
    localparam int DEPTH_W = MAX_EXP + 2
) (
    input  logic               clk,
    input  logic               rst,
    output logic               ee_cs,
    output logic               ee_sk,
    output logic               ee_di,
    input  logic               ee_do,
    input  logic [4:0]         tgt_sel,
    output logic [7:0]         tgt_byte,
    output logic               cfg_done,
    output logic               cfg_valid,
    output logic [7:0]         bus_id,
    output logic [DEPTH_W-1:0] queue_depth,
    output logic               act_neg
);
    logic              tick;
    logic              word_stb;
    logic [ADDR_W-1:0] word_idx;
    logic [WORD_W-1:0] word_data;

    eecfg_tick #(.HALF_CYC(HALF_CYC)) u_tick (
        .clk (clk),
        .rst (rst),
        .tick(tick)
    );

    eecfg_serial u_serial (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .ee_do    (ee_do),
        .ee_cs    (ee_cs),
        .ee_sk    (ee_sk),
        .ee_di    (ee_di),
        .word_stb (word_stb),
        .word_idx (word_idx),
        .word_data(word_data)
    );

    eecfg_image #(.MAX_EXP(MAX_EXP), .DEPTH_W(DEPTH_W)) u_image (
        .clk        (clk),
        .rst        (rst),
        .word_stb   (word_stb),
        .word_idx   (word_idx),
        .word_data  (word_data),
        .tgt_sel    (tgt_sel),
        .tgt_byte   (tgt_byte),
        .cfg_done   (cfg_done),
        .cfg_valid  (cfg_valid),
        .bus_id     (bus_id),
        .queue_depth(queue_depth),
        .act_neg    (act_neg)
    );

    // R6
    no_clock_after_done_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_done |-> (!ee_cs && !ee_sk));
endmodule

// File: tb/test_eeprom_cfg_loader.sv
module test_eeprom_cfg_loader;
    localparam int H   = 4;
    localparam int DW  = 17;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ee_cs, ee_sk, ee_di;
    logic          ee_do = 1'b0;
    logic [4:0]    tgt_sel = '0;
    logic [7:0]    tgt_byte;
    logic          cfg_done, cfg_valid, act_neg;
    logic [7:0]    bus_id;
    logic [DW-1:0] queue_depth;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    logic [15:0] mem [64];
    logic [8:0]  exp_q [$];

    always #4 clk = ~clk;

    eeprom_cfg_loader #(.HALF_CYC(H)) i_eeprom_cfg_loader (
        .clk(clk), .rst(rst), .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di),
        .ee_do(ee_do), .tgt_sel(tgt_sel), .tgt_byte(tgt_byte),
        .cfg_done(cfg_done), .cfg_valid(cfg_valid), .bus_id(bus_id),
        .queue_depth(queue_depth), .act_neg(act_neg)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    // EEPROM model and command monitor (R2, R4)
    int       rises = 0;
    logic [8:0] cmdsh = '0;
    logic [5:0] addr_seen = '0;
    always @(posedge ee_cs) begin
        rises = 0;
        cmdsh = '0;
    end
    always @(posedge ee_sk) begin
        logic [8:0] e;
        if (!ee_cs) chk(0, "R2", "sk rise with cs low", 0, 1);
        rises++;
        if (rises <= 9) begin
            cmdsh = {cmdsh[7:0], ee_di};
            if (rises == 9) begin
                if (exp_q.size() > 0) e = exp_q.pop_front();
                else e = '0;
                chk(cmdsh == e, "R2", "read command", cmdsh, e);
                addr_seen = cmdsh[5:0];
            end
        end else if (rises <= 25) begin
            ee_do = mem[addr_seen][15 - (rises - 10)];
        end else begin
            chk(0, "R4", "extra serial clock in word", rises, 25);
        end
    end

    // Pulse width and chip-select gap monitor (R3, R5)
    int skh = 0;
    int csl = 0;
    always @(negedge clk) begin
        if (!rst) begin
            if (ee_sk) skh++;
            else if (skh != 0) begin
                chk(skh == H, "R3", "sk high width", skh, H);
                skh = 0;
            end
            if (!ee_cs) csl++;
            else if (csl != 0) begin
                chk(csl >= H, "R5", "cs low gap", csl, H);
                csl = 0;
            end
        end else begin
            skh = 0;
            csl = 0;
        end
    end

    task automatic run_image(input logic [7:0] bid, input logic [7:0] mode,
                             input logic [7:0] dly, input logic [7:0] e,
                             input bit good);
        logic [15:0] s;
        longint exp_depth;
        int n;
        logic [7:0]    sv_id;
        logic [DW-1:0] sv_depth;
        logic          sv_neg, sv_valid;
        s = '0;
        for (int i = 0; i < 64; i++) mem[i] = 16'(i * 16'h0137 + 16'h5ac3 + int'(bid));
        mem[32] = {mode, bid};
        mem[33] = {e, dly};
        for (int i = 0; i < 63; i++) s = s + mem[i];
        mem[63] = 16'h1234 - s + (good ? 16'd0 : 16'd1);
        exp_q.delete();
        for (int i = 0; i < 64; i++) exp_q.push_back({3'b110, 6'(i)});

        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk(!ee_cs && !ee_sk, "R1", "serial idle in reset", {ee_cs, ee_sk}, 0);
        chk(!cfg_done && !cfg_valid, "R1", "flags in reset", {cfg_done, cfg_valid}, 0);
        chk(bus_id == 8'd7 && queue_depth == 0 && !act_neg, "R1", "defaults in reset",
            bus_id, 7);
        rst = 1'b0;

        n = 0;
        while (n < 3840 * H + 100) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (n == 1920 * H)
                chk(!cfg_done && bus_id == 8'd7 && queue_depth == 0 && !act_neg,
                    "R1", "defaults mid-load", bus_id, 7);
            if (cfg_done) break;
        end
        chk(n == 3840 * H + 1, "R6", "done latency", n, 3840 * H + 1);
        chk(exp_q.size() == 0, "R2", "all 64 commands sent", exp_q.size(), 0);

        if (good) begin
            exp_depth = (e > 8'd15) ? 65536 : (longint'(2) << e);
            chk(cfg_valid == 1'b1, "R7", "valid flag", cfg_valid, 1);
            chk(bus_id == bid, "R7", "bus id", bus_id, bid);
            chk(act_neg == mode[3], "R7", "active negation", act_neg, mode[3]);
            chk(longint'(queue_depth) == exp_depth, "R8", "queue depth", queue_depth, exp_depth);
        end else begin
            chk(cfg_valid == 1'b0, "R9", "valid flag", cfg_valid, 0);
            chk(bus_id == 8'd7, "R9", "default bus id", bus_id, 7);
            chk(queue_depth == 0 && !act_neg, "R9", "default depth/neg", queue_depth, 0);
        end

        foreach (mem[k]) if (k == 0) ;
        for (int b = 0; b < 32; b += 7) begin
            logic [7:0] eb;
            tgt_sel = 5'(b);
            #1;
            eb = (b % 2) ? mem[b / 2][15:8] : mem[b / 2][7:0];
            chk(tgt_byte == eb, "R10", "target byte", tgt_byte, eb);
        end
        tgt_sel = 5'd31;
        #1;
        chk(tgt_byte == mem[15][15:8], "R10", "last target byte", tgt_byte, mem[15][15:8]);

        sv_id = bus_id; sv_depth = queue_depth; sv_neg = act_neg; sv_valid = cfg_valid;
        repeat (50) @(negedge clk);
        chk(cfg_done && bus_id == sv_id && queue_depth == sv_depth && act_neg == sv_neg
            && cfg_valid == sv_valid, "R6", "outputs hold after done", bus_id, sv_id);
        chk(!ee_cs && !ee_sk, "R6", "serial quiet after done", {ee_cs, ee_sk}, 0);
    endtask

    initial begin
        run_image(8'd3, 8'h08, 8'h11, 8'd4, 1'b1);
        run_image(8'd3, 8'h08, 8'h11, 8'd4, 1'b0);
        run_image(8'd5, 8'hF7, 8'h22, 8'd20, 1'b1);
        run_image(8'd0, 8'h0C, 8'h00, 8'd15, 1'b1);
        run_image(8'd6, 8'h00, 8'h01, 8'd0, 1'b1);
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule